// File: doc/BRIEF.md
# Branch Delay Slot Annul Controller

This block makes the branch decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) whose branches carry one architectural delay slot. While a branch sits in decode, the instruction right behind it, the slot, sits in fetch. The block tests the branch condition on one source register and computes the next fetch address. It also decides whether the slot instruction is allowed to commit. The redirect takes effect only after the slot, so the slot always enters decode.

Three branch flavours are supported. A plain delayed branch always lets its slot complete. A cancelling branch hinted likely taken discards the slot's effects when the branch falls through. A cancelling branch hinted likely not taken discards them when the branch is taken. A discarded slot is not flushed. It keeps its valid bit and travels down the pipeline with an annul tag, and the tag gates its memory store and its register write. With the delay slot turned off by parameter, a taken branch instead squashes the instruction that was fetched after it, which costs one bubble.

Top module: `slot_annul_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every stage valid and annul tag reads 0, and mem_store_en and wb_reg_we stay 0 even with their requests high.
- R2: A live branch in decode is resolved in the same cycle. For dec_cond=0 it is taken when dec_rs equals zero. For dec_cond=1 it is taken when dec_rs is non-zero.
- R3: next_pc equals dec_pc plus the sign-extended dec_off times four when taken is 1, and fetch_pc plus four otherwise.
- R4: A branch is live only when decode holds a valid instruction that is not annulled (stg_valid[0]=1, stg_annul[0]=0). Otherwise taken is 0 and next_pc is fetch_pc plus four.
- R5: For dec_kind=0 (plain delayed) and dec_kind=3 (reserved, treated as plain), the slot is never annulled.
- R6: For dec_kind=1 (cancelling, likely taken), the slot is annulled when the branch is not taken.
- R7: For dec_kind=2 (cancelling, likely not taken), the slot is annulled when the branch is taken.
- R8: With the delay slot enabled, a valid fetch instruction always enters decode with its valid bit set, and the annul tag is set only on a valid slot. An invalid slot enters with both bits 0.
- R9: Valid and annul tags advance one stage per clock, from index 0 (decode) through 1 (execute) and 2 (memory) to 3 (write-back).
- R10: mem_store_en follows mem_store_req, and wb_reg_we follows wb_reg_we_req, only for a valid, non-annulled instruction in the memory and write-back stage respectively. Otherwise they are 0.
- R11: With the delay slot disabled, a taken branch raises if_squash. The fetched instruction then enters decode invalid, and no annul tag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_valid | input | 1 | Fetch stage holds an instruction |
| fetch_pc | input | 32 | Address of the instruction in fetch |
| dec_is_br | input | 1 | Decode instruction is a conditional branch |
| dec_kind | input | 2 | 0 plain, 1 cancel likely taken, 2 cancel likely not taken, 3 plain |
| dec_cond | input | 1 | 0 branch on zero, 1 branch on non-zero |
| dec_rs | input | 32 | Source register value tested by the branch |
| dec_pc | input | 32 | Address of the branch in decode |
| dec_off | input | 16 | Signed word offset of the branch target |
| mem_store_req | input | 1 | Memory stage instruction wants to store |
| wb_reg_we_req | input | 1 | Write-back instruction wants to write a register |
| taken | output | 1 | Live branch in decode is taken |
| next_pc | output | 32 | Next fetch address |
| if_squash | output | 1 | Fetch instruction is discarded (slot disabled only) |
| stg_valid | output | 4 | Valid tag per stage, index 0 decode to 3 write-back |
| stg_annul | output | 4 | Annul tag per stage, same indexing |
| mem_store_en | output | 1 | Gated store enable |
| wb_reg_we | output | 1 | Gated register write enable |

## Verification
The bench builds two copies side by side on the same stimulus: one with the delay slot enabled and one with it disabled, both with four tag stages and 32-bit addresses. Comparing them on every branch shows that the slot survives as an annulled instruction in the first copy and is squashed into a bubble in the second. It also shows that a branch sitting in an annulled slot has no effect only where annulling exists. Negative offsets and a sign-bit-only register value exercise the target arithmetic and the zero test at their edges.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [1:0] {
      BR_PLAIN     = 2'd0,
      BR_LIKELY_T  = 2'd1,
      BR_LIKELY_NT = 2'd2,
      BR_RSVD      = 2'd3
   } br_kind_e;

   typedef enum logic {
      CND_EQZ = 1'b0,
      CND_NEZ = 1'b1
   } br_cond_e;

   typedef struct packed {
      logic valid;
      logic annul;
   } stage_tag_t;

endpackage

// File: rtl/sac_resolve.sv
module sac_resolve #(
   parameter int XLEN = 32,
   parameter int PCW  = 32,
   parameter int OFFW = 16
) (
   input  logic              live,
   input  sac_pkg::br_cond_e cond,
   input  logic [XLEN-1:0]   rs,
   input  logic [PCW-1:0]    br_pc,
   input  logic [OFFW-1:0]   off,
   input  logic [PCW-1:0]    fetch_pc,
   output logic              cond_true,
   output logic              taken,
   output logic [PCW-1:0]    next_pc
);
   import sac_pkg::*;

   localparam int EXTW = PCW - OFFW;

   logic            rs_zero;
   logic [PCW-1:0]  off_ext;
   logic [PCW-1:0]  target;
   logic [PCW-1:0]  seq_pc;

   assign rs_zero = (rs == '0);

   always_comb begin
      unique case (cond)
         CND_EQZ: cond_true = rs_zero;
         CND_NEZ: cond_true = ~rs_zero;
         default: cond_true = 1'b0;
      endcase
   end

   assign off_ext = {{EXTW{off[OFFW-1]}}, off};
   assign target  = br_pc + (off_ext << 2);
   assign seq_pc  = fetch_pc + PCW'(4);
   assign taken   = live & cond_true;
   assign next_pc = taken ? target : seq_pc;

endmodule

// File: rtl/sac_annul_dec.sv
module sac_annul_dec #(
   parameter bit SLOT_EN = 1'b1
) (
   input  logic              live,
   input  sac_pkg::br_kind_e kind,
   input  logic              cond_true,
   output logic              annul_slot,
   output logic              squash
);
   import sac_pkg::*;

   localparam logic HAS_SLOT = SLOT_EN;

   logic annul_raw;

   always_comb begin
      unique case (kind)
         BR_LIKELY_T:  annul_raw = ~cond_true;
         BR_LIKELY_NT: annul_raw = cond_true;
         default:      annul_raw = 1'b0;
      endcase
   end

   assign annul_slot = HAS_SLOT & live & annul_raw;
   assign squash     = ~HAS_SLOT & live & cond_true;

endmodule

// File: rtl/sac_tag_pipe.sv
module sac_tag_pipe #(
   parameter int NSTG = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_annul,
   output logic [NSTG-1:0] stg_valid,
   output logic [NSTG-1:0] stg_annul
);
   import sac_pkg::*;

   stage_tag_t tags [NSTG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tags[0] <= '0;
      end else begin
         tags[0].valid <= in_valid;
         tags[0].annul <= in_valid & in_annul;
      end
   end

   for (genvar s = 1; s < NSTG; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tags[s] <= '0;
         else        tags[s] <= tags[s-1];
      end
   end

   for (genvar s = 0; s < NSTG; s++) begin : g_out
      assign stg_valid[s] = tags[s].valid;
      assign stg_annul[s] = tags[s].annul;
   end

endmodule

// File: rtl/slot_annul_ctrl.sv
module slot_annul_ctrl #(
   parameter int XLEN    = 32,
   parameter int PCW     = 32,
   parameter int OFFW    = 16,
   parameter int NSTG    = 4,
   parameter bit SLOT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid,
   input  logic [PCW-1:0]  fetch_pc,
   input  logic            dec_is_br,
   input  logic [1:0]      dec_kind,
   input  logic            dec_cond,
   input  logic [XLEN-1:0] dec_rs,
   input  logic [PCW-1:0]  dec_pc,
   input  logic [OFFW-1:0] dec_off,
   input  logic            mem_store_req,
   input  logic            wb_reg_we_req,
   output logic            taken,
   output logic [PCW-1:0]  next_pc,
   output logic            if_squash,
   output logic [NSTG-1:0] stg_valid,
   output logic [NSTG-1:0] stg_annul,
   output logic            mem_store_en,
   output logic            wb_reg_we
);
   import sac_pkg::*;

   localparam int ID_IDX  = 0;
   localparam int MEM_IDX = NSTG - 2;
   localparam int WB_IDX  = NSTG - 1;

   if (NSTG < 3) begin : g_bad_nstg
      $error("slot_annul_ctrl: NSTG must be at least 3");
   end
   if (OFFW >= PCW) begin : g_bad_offw
      $error("slot_annul_ctrl: OFFW must be narrower than PCW");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("slot_annul_ctrl: XLEN must be positive");
   end

   logic br_live;
   logic cond_true;
   logic annul_slot;
   logic squash;

   assign br_live = dec_is_br & stg_valid[ID_IDX] & ~stg_annul[ID_IDX];

   sac_resolve #(
      .XLEN(XLEN),
      .PCW (PCW),
      .OFFW(OFFW)
   ) u_resolve (
      .live     (br_live),
      .cond     (br_cond_e'(dec_cond)),
      .rs       (dec_rs),
      .br_pc    (dec_pc),
      .off      (dec_off),
      .fetch_pc (fetch_pc),
      .cond_true(cond_true),
      .taken    (taken),
      .next_pc  (next_pc)
   );

   sac_annul_dec #(
      .SLOT_EN(SLOT_EN)
   ) u_annul (
      .live      (br_live),
      .kind      (br_kind_e'(dec_kind)),
      .cond_true (cond_true),
      .annul_slot(annul_slot),
      .squash    (squash)
   );

   sac_tag_pipe #(
      .NSTG(NSTG)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (if_valid & ~squash),
      .in_annul (annul_slot),
      .stg_valid(stg_valid),
      .stg_annul(stg_annul)
   );

   assign if_squash    = squash;
   assign mem_store_en = mem_store_req & stg_valid[MEM_IDX] & ~stg_annul[MEM_IDX];
   assign wb_reg_we    = wb_reg_we_req & stg_valid[WB_IDX] & ~stg_annul[WB_IDX];

endmodule

// File: rtl/sac_chk.sv
module sac_chk #(
   parameter int NSTG    = 4,
   parameter bit SLOT_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            if_valid,
   input logic            dec_is_br,
   input logic            taken,
   input logic            if_squash,
   input logic [NSTG-1:0] stg_valid,
   input logic [NSTG-1:0] stg_annul,
   input logic            mem_store_en,
   input logic            wb_reg_we
);

   localparam int MEM_IDX = NSTG - 2;
   localparam int WB_IDX  = NSTG - 1;

   for (genvar s = 1; s < NSTG; s++) begin : g_shift
      // R9
      tag_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (stg_valid[s] == $past(stg_valid[s-1])) &&
                  (stg_annul[s] == $past(stg_annul[s-1])));
   end

   // R4
   live_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (dec_is_br && stg_valid[0] && !stg_annul[0]));

   // R10
   store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_store_en |-> (stg_valid[MEM_IDX] && !stg_annul[MEM_IDX]));

   // R10
   regwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_reg_we |-> (stg_valid[WB_IDX] && !stg_annul[WB_IDX]));

   // R6
   annul_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_annul[0] |-> ($past(dec_is_br) && $past(if_valid)));

   if (SLOT_EN) begin : g_slot
      // R8
      slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         if_valid |=> stg_valid[0]);
      // R8
      no_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !if_squash);
   end else begin : g_noslot
      // R11
      no_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stg_annul == '0);
      // R11
      squash_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
         if_squash |-> taken);
   end

endmodule

bind slot_annul_ctrl sac_chk #(.NSTG(NSTG), .SLOT_EN(SLOT_EN)) u_chk (.*);

// File: tb/slot_annul_ctrl_test.sv
module slot_annul_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        if_valid;
   logic [31:0] fetch_pc;
   logic        dec_is_br;
   logic [1:0]  dec_kind;
   logic        dec_cond;
   logic [31:0] dec_rs;
   logic [31:0] dec_pc;
   logic [15:0] dec_off;
   logic        mem_store_req;
   logic        wb_reg_we_req;

   logic        taken_d, squash_d, mst_d, wbe_d;
   logic [31:0] npc_d;
   logic [3:0]  sv_d, sa_d;
   logic        taken_n, squash_n, mst_n, wbe_n;
   logic [31:0] npc_n;
   logic [3:0]  sv_n, sa_n;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   slot_annul_ctrl #(.SLOT_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .fetch_pc(fetch_pc),
      .dec_is_br(dec_is_br), .dec_kind(dec_kind), .dec_cond(dec_cond),
      .dec_rs(dec_rs), .dec_pc(dec_pc), .dec_off(dec_off),
      .mem_store_req(mem_store_req), .wb_reg_we_req(wb_reg_we_req),
      .taken(taken_d), .next_pc(npc_d), .if_squash(squash_d),
      .stg_valid(sv_d), .stg_annul(sa_d),
      .mem_store_en(mst_d), .wb_reg_we(wbe_d));

   slot_annul_ctrl #(.SLOT_EN(1'b0)) uut_nd (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .fetch_pc(fetch_pc),
      .dec_is_br(dec_is_br), .dec_kind(dec_kind), .dec_cond(dec_cond),
      .dec_rs(dec_rs), .dec_pc(dec_pc), .dec_off(dec_off),
      .mem_store_req(mem_store_req), .wb_reg_we_req(wb_reg_we_req),
      .taken(taken_n), .next_pc(npc_n), .if_squash(squash_n),
      .stg_valid(sv_n), .stg_annul(sa_n),
      .mem_store_en(mst_n), .wb_reg_we(wbe_n));

   typedef struct packed {
      logic [1:0]  kind;
      logic        cond;
      logic [31:0] rs;
      logic [15:0] off;
      logic [31:0] pc;
      logic        et;
      logic        ea;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b0, 32'h0000_0000, 16'h0010, 32'h0000_1000, 1'b1, 1'b0},
      '{2'd0, 1'b1, 32'h0000_0000, 16'h0020, 32'h0000_2000, 1'b0, 1'b0},
      '{2'd1, 1'b0, 32'h0000_0000, 16'hFFFE, 32'h0000_3000, 1'b1, 1'b0},
      '{2'd1, 1'b0, 32'h0000_0005, 16'h0004, 32'h0000_4000, 1'b0, 1'b1},
      '{2'd2, 1'b1, 32'h0000_0007, 16'h8000, 32'h0004_0000, 1'b1, 1'b1},
      '{2'd2, 1'b1, 32'h0000_0000, 16'h0040, 32'h0000_5000, 1'b0, 1'b0},
      '{2'd1, 1'b1, 32'h8000_0000, 16'h7FFF, 32'h0000_6000, 1'b1, 1'b0},
      '{2'd3, 1'b0, 32'h0000_0001, 16'h0008, 32'h0000_7000, 1'b0, 1'b0}
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      if_valid      = 1'b0;
      dec_is_br     = 1'b0;
      dec_kind      = 2'd0;
      dec_cond      = 1'b0;
      dec_rs        = 32'h1;
      dec_pc        = 32'h0;
      dec_off       = 16'h0;
      fetch_pc      = 32'h100;
      mem_store_req = 1'b0;
      wb_reg_we_req = 1'b0;
   endtask

   function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [15:0] off);
      return pc + ({{16{off[15]}}, off} << 2);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      dec_is_br = 1'b1;
      dec_rs    = 32'h0;
      mem_store_req = 1'b1;
      wb_reg_we_req = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R1 during reset
      chk("R1 valid tags in reset", {28'h0, sv_d}, 32'h0);
      chk("R1 annul tags in reset", {28'h0, sa_d}, 32'h0);
      chk("R1 store gated in reset", {31'h0, mst_d}, 32'h0);
      chk("R1 regwr gated in reset", {31'h0, wbe_d}, 32'h0);
      rst_n = 1'b1;
      #2;
      // R4 a branch in an empty decode stage is ignored
      chk("R4 empty decode not taken", {31'h0, taken_d}, 32'h0);
      chk("R4 empty decode next_pc", npc_d, 32'h104);
      chk("R1 no squash after reset", {31'h0, squash_n}, 32'h0);
      idle_inputs();
      step();

      // vector walk: R2 R3 R5 R6 R7 R8 R9 R10 R11
      for (int i = 0; i < NV; i++) begin
         logic [31:0] epc;
         idle_inputs();
         if_valid = 1'b1;
         step();
         dec_is_br = 1'b1;
         dec_kind  = VECS[i].kind;
         dec_cond  = VECS[i].cond;
         dec_rs    = VECS[i].rs;
         dec_pc    = VECS[i].pc;
         dec_off   = VECS[i].off;
         fetch_pc  = VECS[i].pc + 32'd4;
         if_valid  = 1'b1;
         epc = VECS[i].et ? exp_target(VECS[i].pc, VECS[i].off) : VECS[i].pc + 32'd8;
         #2;
         chk($sformatf("R2 taken v%0d", i), {31'h0, taken_d}, {31'h0, VECS[i].et});
         chk($sformatf("R3 next_pc v%0d", i), npc_d, epc);
         chk($sformatf("R11 squash v%0d", i), {31'h0, squash_n}, {31'h0, VECS[i].et});
         step();
         chk($sformatf("R8 slot valid v%0d", i), {31'h0, sv_d[0]}, 32'h1);
         chk($sformatf("R6 R7 R5 slot annul v%0d", i), {31'h0, sa_d[0]}, {31'h0, VECS[i].ea});
         chk($sformatf("R11 nodelay slot valid v%0d", i), {31'h0, sv_n[0]}, {31'h0, ~VECS[i].et});
         idle_inputs();
         step();
         chk($sformatf("R9 annul at execute v%0d", i), {31'h0, sa_d[1]}, {31'h0, VECS[i].ea});
         step();
         mem_store_req = 1'b1;
         #1;
         chk($sformatf("R10 store en v%0d", i), {31'h0, mst_d}, {31'h0, ~VECS[i].ea});
         chk($sformatf("R11 nodelay store en v%0d", i), {31'h0, mst_n}, {31'h0, ~VECS[i].et});
         mem_store_req = 1'b0;
         step();
         wb_reg_we_req = 1'b1;
         #1;
         chk($sformatf("R10 regwr en v%0d", i), {31'h0, wbe_d}, {31'h0, ~VECS[i].ea});
         chk($sformatf("R11 nodelay regwr en v%0d", i), {31'h0, wbe_n}, {31'h0, ~VECS[i].et});
         wb_reg_we_req = 1'b0;
      end

      // R4 a branch sitting in an annulled slot has no effect
      idle_inputs();
      if_valid = 1'b1;
      step();
      dec_is_br = 1'b1;
      dec_kind  = 2'd1;
      dec_cond  = 1'b0;
      dec_rs    = 32'h5;
      dec_pc    = 32'h8000;
      dec_off   = 16'h0010;
      fetch_pc  = 32'h8004;
      if_valid  = 1'b1;
      step();
      chk("R6 cancelled slot annulled", {31'h0, sa_d[0]}, 32'h1);
      dec_is_br = 1'b1;
      dec_kind  = 2'd0;
      dec_cond  = 1'b0;
      dec_rs    = 32'h0;
      dec_pc    = 32'h8004;
      dec_off   = 16'h0100;
      fetch_pc  = 32'h8008;
      if_valid  = 1'b0;
      #1;
      chk("R4 annulled branch not taken", {31'h0, taken_d}, 32'h0);
      chk("R4 annulled branch next_pc", npc_d, 32'h800C);
      chk("R11 nodelay branch live", {31'h0, taken_n}, 32'h1);
      chk("R11 nodelay target", npc_n, 32'h8404);

      // R8 an invalid slot carries no annul tag
      idle_inputs();
      if_valid = 1'b1;
      step();
      dec_is_br = 1'b1;
      dec_kind  = 2'd2;
      dec_cond  = 1'b1;
      dec_rs    = 32'h3;
      dec_pc    = 32'h9000;
      dec_off   = 16'h0004;
      fetch_pc  = 32'h9004;
      if_valid  = 1'b0;
      step();
      chk("R8 invalid slot valid", {31'h0, sv_d[0]}, 32'h0);
      chk("R8 invalid slot annul", {31'h0, sa_d[0]}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule